// File: doc/BRIEF.md
# IrDA SIR Pulse Stretcher

This block turns the short infrared pulses of a serial-infrared link back into the level a UART receiver expects. The optical receiver drives `ir_in`, which idles high. Each falling edge on that line marks one received zero bit, and the bit's pulse covers only about three sixteenths of the bit. The block answers each such edge with a low on `rx_out` that lasts one full bit time: sixteen ticks of the 16x-baud enable `tick_16x`. When `rx_out` is not stretching a pulse, it rests high (mark).

The whole block runs on one system clock that is much faster than the baud tick. The input is brought in through a chain of synchronizer flops, and falling edges are found on every system clock. This way a pulse shorter than one tick period is still detected. A detected edge is held until the next tick, and that tick starts the sixteen-tick stretch. An edge that arrives while a stretch is running restarts the count. Zero bits one bit time apart therefore join into one unbroken low. A synchronous active-low clear resets the block, and while the clear is held, reception is blocked and `rx_out` stays high.

Top module: `sir_rx_stretch`

## Requirements
- R1: While `clear_n` is low, and on the first clock after it was sampled low, `rx_out` is high. After the clear is released, with no falling edge on `ir_in`, `rx_out` stays high.
- R2: A single falling edge on `ir_in` drives `rx_out` low for exactly 16 ticks of `tick_16x`. The low starts on the clock edge where the first tick after the synchronized edge is sampled. With a tick on every 4th clock, that is 64 clocks. The low starts no more than 6 clocks after the input falls.
- R3: An input low only one system clock wide is still detected and stretched to the full 16 ticks, even when no tick falls inside it.
- R4: Falling edges exactly 16 ticks apart give a continuous low with no high gap, lasting 16 ticks per edge.
- R5: A falling edge that arrives during a stretch restarts the count. With the second edge 8 ticks after the first, the low lasts 24 ticks in total.
- R6: Only a falling edge starts a stretch. A low level held past the stretch, or a rising edge, does not keep `rx_out` low or start a new low.
- R7: Falling edges that arrive while `clear_n` is low produce no low on `rx_out`. Asserting `clear_n` during a stretch ends it on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the baud tick |
| clear_n | input | 1 | Synchronous active-low clear; blocks reception while low |
| tick_16x | input | 1 | One-clock enable pulse at 16 times the baud rate |
| ir_in | input | 1 | Pulse input from the optical receiver, idle high |
| rx_out | output | 1 | Stretched serial level for the UART, idle high, registered |

## Verification
The first result after an input fall is the start of the low. It arrives after two synchronizer clocks and one edge-history clock, plus a wait for the next tick, so it falls two to five clocks after the fall is registered. The bench therefore waits up to six clocks for the low to start. After that it counts how many clocks the low lasts, and compares the count with 64 clocks per stretched tick span (64, 96 or 192). All sampling happens on the falling clock edge, and ticks are driven with a fixed phase. Input edges spaced a multiple of four clocks apart therefore land on a known tick, which makes the merged and restarted lengths exact.

// File: rtl/sir_rx_pkg.sv
package sir_rx_pkg;
  // ticks of the 16x enable that make up one bit time
  localparam int unsigned BIT_TICKS   = 16;
  // flops in the input synchronizer chain
  localparam int unsigned SYNC_DEPTH  = 2;
  // level the line rests at when no pulse is present
  localparam logic        LINE_IDLE   = 1'b1;
endpackage

// File: rtl/sir_rx_sync.sv
module sir_rx_sync #(
  parameter int unsigned DEPTH     = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic clear_n,
  input  logic d_in,
  output logic d_sync
);
  logic [DEPTH-1:0] chain_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!clear_n) chain_q <= RESET_VAL;
        else          chain_q <= d_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!clear_n) chain_q <= {DEPTH{RESET_VAL}};
        else          chain_q <= {chain_q[DEPTH-2:0], d_in};
      end
    end
  endgenerate

  assign d_sync = chain_q[DEPTH-1];
endmodule

// File: rtl/sir_rx_edge_hold.sv
module sir_rx_edge_hold (
  input  logic clk,
  input  logic clear_n,
  input  logic line_sync,
  input  logic tick,
  output logic start
);
  logic line_prev_q;
  logic pend_q;
  logic fall;

  // falling edge of the synchronized line, found on every system clock
  assign fall  = line_prev_q & ~line_sync;
  // a held or fresh edge is released on the next tick
  assign start = tick & (pend_q | fall);

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      line_prev_q <= 1'b1;
      pend_q      <= 1'b0;
    end else begin
      line_prev_q <= line_sync;
      if (tick) pend_q <= 1'b0;
      else if (fall) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sir_rx_stretch_cnt.sv
module sir_rx_stretch_cnt #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk,
  input  logic clear_n,
  input  logic tick,
  input  logic start,
  output logic level
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          level_q;

  always_comb begin
    cnt_d = cnt_q;
    if (start)                          cnt_d = LOAD;
    else if (tick && cnt_q != '0)       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      cnt_q   <= '0;
      level_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      level_q <= (cnt_d == '0);
    end
  end

  assign level = level_q;
endmodule

// File: rtl/sir_rx_stretch.sv
module sir_rx_stretch
  import sir_rx_pkg::*;
#(
  parameter int unsigned TICKS = BIT_TICKS,
  parameter int unsigned SYNC  = SYNC_DEPTH
) (
  input  logic clk,
  input  logic clear_n,
  input  logic tick_16x,
  input  logic ir_in,
  output logic rx_out
);
  logic line_sync;
  logic start;

  sir_rx_sync #(.DEPTH(SYNC), .RESET_VAL(LINE_IDLE)) u_sync (
    .clk     (clk),
    .clear_n (clear_n),
    .d_in    (ir_in),
    .d_sync  (line_sync)
  );

  sir_rx_edge_hold u_edge (
    .clk       (clk),
    .clear_n   (clear_n),
    .line_sync (line_sync),
    .tick      (tick_16x),
    .start     (start)
  );

  sir_rx_stretch_cnt #(.TICKS(TICKS)) u_cnt (
    .clk     (clk),
    .clear_n (clear_n),
    .tick    (tick_16x),
    .start   (start),
    .level   (rx_out)
  );
endmodule

// File: rtl/sir_rx_stretch_chk.sv
module sir_rx_stretch_chk #(
  parameter int unsigned TICKS = 16
) (
  input logic clk,
  input logic clear_n,
  input logic tick_16x,
  input logic rx_out
);
  logic [7:0] low_ticks;

  always_ff @(posedge clk) begin
    if (!clear_n || rx_out) low_ticks <= '0;
    else if (tick_16x && low_ticks != 8'hFF) low_ticks <= low_ticks + 1'b1;
  end

  // R1
  clear_idle_chk: assert property (@(posedge clk) !clear_n |=> rx_out);

  // R2
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!clear_n)
    ($fell(rx_out) && $past(clear_n)) |-> $past(tick_16x));

  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!clear_n)
    ($rose(rx_out) && $past(clear_n)) |-> $past(tick_16x));

  // R4
  min_stretch_chk: assert property (@(posedge clk) disable iff (!clear_n)
    ($rose(rx_out) && $past(clear_n)) |-> (low_ticks >= 8'(TICKS)));
endmodule

bind sir_rx_stretch sir_rx_stretch_chk #(.TICKS(TICKS)) u_chk (
  .clk      (clk),
  .clear_n  (clear_n),
  .tick_16x (tick_16x),
  .rx_out   (rx_out)
);

// File: tb/tb_sir_rx_stretch.sv
module tb_sir_rx_stretch;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic clear_n = 1'b0;
  logic tick_16x = 1'b0;
  logic ir_in = 1'b1;
  logic rx_out;

  int n_checks = 0;
  int n_fail = 0;
  int tick_cnt = 0;

  sir_rx_stretch dut (
    .clk(clk), .clear_n(clear_n), .tick_16x(tick_16x), .ir_in(ir_in), .rx_out(rx_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
    tick_16x <= (tick_cnt == TICK_DIV-1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // align to a fixed tick phase so edge spacing maps to whole ticks
  task automatic align();
    @(negedge clk);
    while (tick_cnt != 0) @(negedge clk);
  endtask

  task automatic measure(output int lat, output int len);
    lat = 0; len = 0;
    while (rx_out && lat < 50) begin @(negedge clk); lat++; end
    while (!rx_out && len < 2000) begin @(negedge clk); len++; end
  endtask

  task automatic pulse(input int width);
    ir_in = 1'b0;
    cycles(width);
    ir_in = 1'b1;
  endtask

  task automatic t_reset();
    int highs = 0;
    clear_n = 1'b0;
    cycles(3);
    check(rx_out == 1'b1, "R1 clear", rx_out, 1);
    clear_n = 1'b1;
    for (int i = 0; i < 200; i++) begin @(negedge clk); highs += rx_out; end
    check(highs == 200, "R1 idle", highs, 200);
  endtask

  task automatic t_single();
    int lat, len;
    align();
    fork
      pulse(12);
      measure(lat, len);
    join
    check(lat <= 6, "R2 latency", lat, 6);
    check(len == BIT_CLKS, "R2 length", len, BIT_CLKS);
    cycles(20);
  endtask

  task automatic t_short();
    int lat, len;
    align(); cycles(1);
    fork
      pulse(1);
      measure(lat, len);
    join
    check(lat <= 6, "R3 latency", lat, 6);
    check(len == BIT_CLKS, "R3 length", len, BIT_CLKS);
    cycles(20);
  endtask

  task automatic t_train();
    int lat, len;
    align();
    fork
      begin
        for (int k = 0; k < 3; k++) begin pulse(12); cycles(BIT_CLKS - 12); end
      end
      measure(lat, len);
    join
    check(len == 3 * BIT_CLKS, "R4 merged", len, 3 * BIT_CLKS);
    cycles(20);
  endtask

  task automatic t_retrig();
    int lat, len;
    align();
    fork
      begin pulse(12); cycles(BIT_CLKS/2 - 12); pulse(12); end
      measure(lat, len);
    join
    check(len == BIT_CLKS + BIT_CLKS/2, "R5 restart", len, BIT_CLKS + BIT_CLKS/2);
    cycles(20);
  endtask

  task automatic t_level();
    int lat, len, highs;
    align();
    fork
      pulse(200);
      measure(lat, len);
    join
    check(len == BIT_CLKS, "R6 level held", len, BIT_CLKS);
    highs = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); highs += rx_out; end
    check(highs == 100, "R6 rising edge", highs, 100);
  endtask

  task automatic t_clear();
    int highs = 0, lat, len;
    clear_n = 1'b0;
    fork
      begin pulse(12); cycles(30); pulse(1); end
      for (int i = 0; i < 80; i++) begin @(negedge clk); highs += rx_out; end
    join
    check(highs == 80, "R7 blocked", highs, 80);
    clear_n = 1'b1;
    highs = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); highs += rx_out; end
    check(highs == 80, "R7 after release", highs, 80);
    align();
    pulse(12);
    measure(lat, len);
    check(lat < 50, "R7 stretch began", lat, 0);
    // restart a stretch and cut it with the clear
    align();
    pulse(12);
    cycles(10);
    check(rx_out == 1'b0, "R7 mid stretch", rx_out, 0);
    clear_n = 1'b0;
    cycles(1);
    check(rx_out == 1'b1, "R7 cut", rx_out, 1);
    clear_n = 1'b1;
    cycles(100);
    check(rx_out == 1'b1, "R7 stays idle", rx_out, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single();
        t_short();
        t_train();
        t_retrig();
        t_level();
        t_clear();
      end
      begin
        cycles(100000);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule